// File: doc/BRIEF.md
# Slow Interleaved Dual-Converter Scheduler

This block drives two analog-to-digital converters that take turns sampling the same regular channel, so the pair delivers samples faster than either converter could alone. A single trigger arms a free-running schedule. It then starts the secondary converter once per period of converter-clock ticks, and starts the primary converter half a period after each secondary start. The converter clock is given to the block as a clock-enable on the system clock. No further trigger is needed while the mode stays enabled.

Each end of conversion from the primary converter packs the most recent secondary result and the new primary result into one data word. The same event raises an optional one-cycle interrupt and a DMA request. The request is held until it is acknowledged. A second request that arrives while the first is still pending marks an overrun.

While the mode is active, the block also forces the continuous-conversion control off. Any injected-group trigger is refused and flagged as an error. When the mode is dropped, no further starts are issued. Results of conversions already in flight are still reported.

Top module: `ilv_dual_sched`

## Requirements
- R1: A start run begins only on a clock edge where `trig` is high, `mode_en` is high and no run is active. The first `sec_start` pulse appears after the first `conv_ce` edge that follows. Later `sec_start` pulses follow every PERIOD (default 28) `conv_ce` edges with no further trigger.
- R2: Each `pri_start` pulse follows the preceding `sec_start` pulse by exactly OFFSET (default 14) `conv_ce` edges. The two start pulses are never high together.
- R3: `cont_eff` equals `cont_req` while `mode_en` is low, and is forced to 0 while `mode_en` is high.
- R4: `irq` is a one-cycle pulse in the cycle after a clock edge where `pri_eoc` and `eoc_ie` are both high. Otherwise it is 0.
- R5: `dma_req` rises in the cycle after a clock edge where `pri_eoc` and `dma_en` are both high. It stays high until an edge where `dma_ack` is high and no new request arrives. With `dma_en` low, `pri_eoc` leaves `dma_req` at 0.
- R6: On each `pri_eoc`, `data_word` is loaded with the latest secondary result in bits 31:16 and `pri_res` in bits 15:0. A `sec_eoc` on the same edge supplies its own `sec_res` to bits 31:16. A `sec_eoc` alone leaves `data_word` unchanged.
- R7: An `inj_trig` while `mode_en` is high is ignored, so `inj_start` stays 0. It also sets the sticky `inj_err`. With `mode_en` low, `inj_trig` produces a one-cycle `inj_start` pulse on the next cycle and `inj_err` is not set.
- R8: The schedule phase advances only on edges where `conv_ce` is high. Every new run starts at phase 0.
- R9: From the cycle after an edge with `mode_en` low, no start pulse is issued. A `pri_eoc` arriving after the mode was dropped still updates `data_word`, `irq` and `dma_req`.
- R10: A clock edge with `pri_eoc` and `dma_en` high, `dma_req` already high and `dma_ack` low sets `ovr_flag`. Only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_ce | input | 1 | Converter-clock tick enable |
| mode_en | input | 1 | Interleaved mode enable |
| trig | input | 1 | Start trigger for the regular channel |
| cont_req | input | 1 | Requested continuous-conversion control |
| eoc_ie | input | 1 | Interrupt enable for primary end of conversion |
| dma_en | input | 1 | DMA request enable |
| dma_ack | input | 1 | DMA acknowledge, clears a pending request |
| inj_trig | input | 1 | Injected-group trigger |
| pri_eoc | input | 1 | Primary converter end-of-conversion strobe |
| pri_res | input | RES_W | Primary converter result |
| sec_eoc | input | 1 | Secondary converter end-of-conversion strobe |
| sec_res | input | RES_W | Secondary converter result |
| sec_start | output | 1 | Start pulse to the secondary converter |
| pri_start | output | 1 | Start pulse to the primary converter |
| cont_eff | output | 1 | Effective continuous-conversion control |
| inj_start | output | 1 | Injected-group start passed through when legal |
| inj_err | output | 1 | Sticky illegal injected-trigger flag |
| data_word | output | 2*RES_W | Packed word {secondary, primary} |
| irq | output | 1 | End-of-conversion interrupt pulse |
| dma_req | output | 1 | DMA request, held until acknowledged |
| ovr_flag | output | 1 | Sticky DMA overrun flag |

## Verification
All registered results (`irq`, `dma_req`, `data_word`, `ovr_flag`, `inj_start`, `inj_err`) are due in the cycle right after the edge that sees their cause. Start pulses are due after the tick edge where the phase reaches 0 (secondary) or OFFSET (primary). With the tick always on, the bench expects them on edges 1, 15, 29 and 43 after the trigger edge. With the tick on every second edge, the expected distances double. `cont_eff` is combinational and is read a short delay after its inputs change. The bench drives every input at the falling edge, waits for one rising edge, and samples at the next falling edge. Each expected value is therefore tied to a known edge count.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
   typedef enum logic [0:0] {
      LANE_PRI = 1'b0,
      LANE_SEC = 1'b1
   } lane_e;

   localparam int unsigned DEF_RES_W  = 16;
   localparam int unsigned DEF_PERIOD = 28;
   localparam int unsigned DEF_OFFSET = 14;
endpackage

// File: rtl/ilv_phase_gen.sv
module ilv_phase_gen #(
   parameter int unsigned PERIOD = 28,
   parameter int unsigned OFFSET = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic conv_ce,
   input  logic mode_en,
   input  logic trig,
   output logic sec_start,
   output logic pri_start
);
   localparam int unsigned PW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
   localparam logic [PW-1:0] OFF_V  = PW'(OFFSET);
   localparam logic [PW-1:0] LAST_V = PW'(PERIOD - 1);

   initial begin : elab_chk
      if (PERIOD < 2) $fatal(1, "PERIOD must be at least 2");
      if (OFFSET == 0 || OFFSET >= PERIOD) $fatal(1, "OFFSET must lie in 1..PERIOD-1");
   end

   logic          running;
   logic [PW-1:0] phase;
   logic [PW-1:0] phase_nxt;

   generate
      if ((2 ** PW) == PERIOD) begin : g_wrap_free
         assign phase_nxt = phase + PW'(1);
      end else begin : g_wrap_cmp
         assign phase_nxt = (phase == LAST_V) ? '0 : phase + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running   <= 1'b0;
         phase     <= '0;
         sec_start <= 1'b0;
         pri_start <= 1'b0;
      end else begin
         sec_start <= 1'b0;
         pri_start <= 1'b0;
         if (!mode_en) begin
            running <= 1'b0;
            phase   <= '0;
         end else if (!running) begin
            if (trig) begin
               running <= 1'b1;
               phase   <= '0;
            end
         end else if (conv_ce) begin
            sec_start <= (phase == '0);
            pri_start <= (phase == OFF_V);
            phase     <= phase_nxt;
         end
      end
   end
endmodule

// File: rtl/ilv_result_pack.sv
module ilv_result_pack #(
   parameter int unsigned RES_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pri_eoc,
   input  logic [RES_W-1:0]   pri_res,
   input  logic               sec_eoc,
   input  logic [RES_W-1:0]   sec_res,
   input  logic               eoc_ie,
   output logic [2*RES_W-1:0] data_word,
   output logic               irq
);
   import ilv_pkg::*;

   initial begin : elab_chk
      if (RES_W < 1) $fatal(1, "RES_W must be positive");
   end

   logic [1:0]            lane_eoc;
   logic [RES_W-1:0]      lane_res [2];
   logic [1:0][RES_W-1:0] fresh;

   assign lane_eoc[int'(LANE_PRI)] = pri_eoc;
   assign lane_eoc[int'(LANE_SEC)] = sec_eoc;
   assign lane_res[int'(LANE_PRI)] = pri_res;
   assign lane_res[int'(LANE_SEC)] = sec_res;

   generate
      for (genvar g = 0; g < 2; g++) begin : g_lane
         logic [RES_W-1:0] held_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) held_q <= '0;
            else if (lane_eoc[g]) held_q <= lane_res[g];
         end
         assign fresh[g] = lane_eoc[g] ? lane_res[g] : held_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_word <= '0;
         irq       <= 1'b0;
      end else begin
         irq <= pri_eoc & eoc_ie;
         if (pri_eoc) data_word <= {fresh[int'(LANE_SEC)], fresh[int'(LANE_PRI)]};
      end
   end
endmodule

// File: rtl/ilv_dma_ctl.sv
module ilv_dma_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic pri_eoc,
   input  logic dma_en,
   input  logic dma_ack,
   output logic dma_req,
   output logic ovr_flag
);
   logic fire;
   assign fire = pri_eoc & dma_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dma_req  <= 1'b0;
         ovr_flag <= 1'b0;
      end else begin
         if (fire && dma_req && !dma_ack) ovr_flag <= 1'b1;
         if (fire) dma_req <= 1'b1;
         else if (dma_ack) dma_req <= 1'b0;
      end
   end
endmodule

// File: rtl/ilv_guard.sv
module ilv_guard (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_en,
   input  logic cont_req,
   input  logic inj_trig,
   output logic cont_eff,
   output logic inj_start,
   output logic inj_err
);
   assign cont_eff = cont_req & ~mode_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inj_start <= 1'b0;
         inj_err   <= 1'b0;
      end else begin
         inj_start <= inj_trig & ~mode_en;
         if (inj_trig && mode_en) inj_err <= 1'b1;
      end
   end
endmodule

// File: rtl/ilv_dual_sched.sv
module ilv_dual_sched #(
   parameter int unsigned RES_W  = ilv_pkg::DEF_RES_W,
   parameter int unsigned PERIOD = ilv_pkg::DEF_PERIOD,
   parameter int unsigned OFFSET = ilv_pkg::DEF_OFFSET
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                conv_ce,
   input  logic                mode_en,
   input  logic                trig,
   input  logic                cont_req,
   input  logic                eoc_ie,
   input  logic                dma_en,
   input  logic                dma_ack,
   input  logic                inj_trig,
   input  logic                pri_eoc,
   input  logic [RES_W-1:0]    pri_res,
   input  logic                sec_eoc,
   input  logic [RES_W-1:0]    sec_res,
   output logic                sec_start,
   output logic                pri_start,
   output logic                cont_eff,
   output logic                inj_start,
   output logic                inj_err,
   output logic [2*RES_W-1:0]  data_word,
   output logic                irq,
   output logic                dma_req,
   output logic                ovr_flag
);
   ilv_phase_gen #(.PERIOD(PERIOD), .OFFSET(OFFSET)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .conv_ce   (conv_ce),
      .mode_en   (mode_en),
      .trig      (trig),
      .sec_start (sec_start),
      .pri_start (pri_start)
   );

   ilv_result_pack #(.RES_W(RES_W)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .pri_eoc   (pri_eoc),
      .pri_res   (pri_res),
      .sec_eoc   (sec_eoc),
      .sec_res   (sec_res),
      .eoc_ie    (eoc_ie),
      .data_word (data_word),
      .irq       (irq)
   );

   ilv_dma_ctl u_dma (
      .clk      (clk),
      .rst_n    (rst_n),
      .pri_eoc  (pri_eoc),
      .dma_en   (dma_en),
      .dma_ack  (dma_ack),
      .dma_req  (dma_req),
      .ovr_flag (ovr_flag)
   );

   ilv_guard u_guard (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_en   (mode_en),
      .cont_req  (cont_req),
      .inj_trig  (inj_trig),
      .cont_eff  (cont_eff),
      .inj_start (inj_start),
      .inj_err   (inj_err)
   );
endmodule

// File: rtl/ilv_dual_sched_chk.sv
module ilv_dual_sched_chk #(
   parameter int unsigned RES_W  = 16,
   parameter int unsigned PERIOD = 28,
   parameter int unsigned OFFSET = 14
) (
   input logic               clk,
   input logic               rst_n,
   input logic               conv_ce,
   input logic               mode_en,
   input logic               cont_req,
   input logic               eoc_ie,
   input logic               dma_en,
   input logic               dma_ack,
   input logic               inj_trig,
   input logic               pri_eoc,
   input logic [RES_W-1:0]   pri_res,
   input logic               sec_start,
   input logic               pri_start,
   input logic               cont_eff,
   input logic               inj_start,
   input logic               inj_err,
   input logic [2*RES_W-1:0] data_word,
   input logic               irq,
   input logic               dma_req,
   input logic               ovr_flag
);
   int unsigned gap;
   logic        seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap  <= 0;
         seen <= 1'b0;
      end else begin
         if (sec_start) gap <= conv_ce ? 1 : 0;
         else if (conv_ce && gap < PERIOD + 1) gap <= gap + 1;
         if (!mode_en) seen <= 1'b0;
         else if (sec_start) seen <= 1'b1;
      end
   end

   assert_sec_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && sec_start) |-> (gap == PERIOD));
   assert_pri_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && pri_start) |-> (gap == OFFSET));
   assert_starts_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(sec_start && pri_start));
   assert_cont_forced_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mode_en |-> !cont_eff);
   assert_cont_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_en |-> (cont_eff == cont_req));
   assert_irq_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pri_eoc && eoc_ie) |=> irq);
   assert_irq_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(pri_eoc && eoc_ie) |=> !irq);
   assert_dma_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pri_eoc && dma_en) |=> dma_req);
   assert_dma_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req && !dma_ack) |=> dma_req);
   assert_pack_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pri_eoc |=> (data_word[RES_W-1:0] == $past(pri_res)));
   assert_pack_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !pri_eoc |=> $stable(data_word));
   assert_inj_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_en && inj_trig) |=> (inj_err && !inj_start));
   assert_inj_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      inj_err |=> inj_err);
   assert_no_start_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_en |=> (!sec_start && !pri_start));
   assert_ovr_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pri_eoc && dma_en && dma_req && !dma_ack) |=> ovr_flag);
   assert_ovr_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_flag |=> ovr_flag);
endmodule

bind ilv_dual_sched ilv_dual_sched_chk #(
   .RES_W(RES_W), .PERIOD(PERIOD), .OFFSET(OFFSET)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .conv_ce   (conv_ce),
   .mode_en   (mode_en),
   .cont_req  (cont_req),
   .eoc_ie    (eoc_ie),
   .dma_en    (dma_en),
   .dma_ack   (dma_ack),
   .inj_trig  (inj_trig),
   .pri_eoc   (pri_eoc),
   .pri_res   (pri_res),
   .sec_start (sec_start),
   .pri_start (pri_start),
   .cont_eff  (cont_eff),
   .inj_start (inj_start),
   .inj_err   (inj_err),
   .data_word (data_word),
   .irq       (irq),
   .dma_req   (dma_req),
   .ovr_flag  (ovr_flag)
);

// File: tb/ilv_dual_sched_bench.sv
module ilv_dual_sched_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conv_ce = 1'b1, mode_en = 1'b0, trig = 1'b0, cont_req = 1'b0;
   logic        eoc_ie = 1'b0, dma_en = 1'b0, dma_ack = 1'b0, inj_trig = 1'b0;
   logic        pri_eoc = 1'b0, sec_eoc = 1'b0;
   logic [15:0] pri_res = '0, sec_res = '0;
   logic        sec_start, pri_start, cont_eff, inj_start, inj_err;
   logic [31:0] data_word;
   logic        irq, dma_req, ovr_flag;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ilv_dual_sched u_ilv_dual_sched (
      .clk(clk), .rst_n(rst_n), .conv_ce(conv_ce), .mode_en(mode_en), .trig(trig),
      .cont_req(cont_req), .eoc_ie(eoc_ie), .dma_en(dma_en), .dma_ack(dma_ack),
      .inj_trig(inj_trig), .pri_eoc(pri_eoc), .pri_res(pri_res), .sec_eoc(sec_eoc),
      .sec_res(sec_res), .sec_start(sec_start), .pri_start(pri_start),
      .cont_eff(cont_eff), .inj_start(inj_start), .inj_err(inj_err),
      .data_word(data_word), .irq(irq), .dma_req(dma_req), .ovr_flag(ovr_flag)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      conv_ce = 1'b1; mode_en = 1'b0; trig = 1'b0; cont_req = 1'b0;
      eoc_ie = 1'b0; dma_en = 1'b0; dma_ack = 1'b0; inj_trig = 1'b0;
      pri_eoc = 1'b0; sec_eoc = 1'b0; pri_res = '0; sec_res = '0;
      tick(); tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic t_reset_state();
      do_reset();
      check("R1 reset sec_start", {31'd0, sec_start}, 0);
      check("R2 reset pri_start", {31'd0, pri_start}, 0);
      check("R6 reset data_word", data_word, 32'h0);
      check("R5 reset dma_req", {31'd0, dma_req}, 0);
      check("R10 reset ovr_flag", {31'd0, ovr_flag}, 0);
   endtask

   // Starts while conv_ce is always on: sec at edges 1, 29; pri at 15, 43.
   task automatic t_schedule();
      int first_sec = -1, second_sec = -1, first_pri = -1, second_pri = -1, pre = 0;
      do_reset();
      trig = 1'b1; tick(); trig = 1'b0;          // trigger with mode off: no run
      mode_en = 1'b1;
      for (int k = 0; k < 30; k++) begin
         tick();
         if (sec_start || pri_start) pre++;
      end
      check("R1 trigger ignored while mode off", pre, 0);
      trig = 1'b1; tick(); trig = 1'b0;
      for (int k = 1; k <= 60; k++) begin
         tick();
         if (sec_start) begin
            if (first_sec < 0) first_sec = k; else if (second_sec < 0) second_sec = k;
         end
         if (pri_start) begin
            if (first_pri < 0) first_pri = k; else if (second_pri < 0) second_pri = k;
         end
      end
      check("R1 first secondary start edge", first_sec, 1);
      check("R1 second secondary start edge", second_sec, 29);
      check("R2 first primary start edge", first_pri, 15);
      check("R2 second primary start edge", second_pri, 43);
   endtask

   // conv_ce on every second edge: all distances double.
   task automatic t_ce_divided();
      int first_sec = -1, second_sec = -1, first_pri = -1;
      do_reset();
      mode_en = 1'b1; conv_ce = 1'b0;
      trig = 1'b1; tick(); trig = 1'b0;
      for (int k = 1; k <= 80; k++) begin
         conv_ce = (k % 2 == 1);
         tick();
         if (sec_start) begin
            if (first_sec < 0) first_sec = k; else if (second_sec < 0) second_sec = k;
         end
         if (pri_start && first_pri < 0) first_pri = k;
      end
      conv_ce = 1'b1;
      check("R8 first secondary start with half-rate tick", first_sec, 1);
      check("R8 primary start with half-rate tick", first_pri, 29);
      check("R8 secondary period with half-rate tick", second_sec, 57);
   endtask

   task automatic t_disable();
      int cnt = 0, first_sec = -1, first_pri = -1;
      do_reset();
      mode_en = 1'b1;
      trig = 1'b1; tick(); trig = 1'b0;
      for (int k = 0; k < 20; k++) tick();
      mode_en = 1'b0;
      for (int k = 0; k < 40; k++) begin
         tick();
         if (sec_start || pri_start) cnt++;
      end
      check("R9 no starts after mode cleared", cnt, 0);
      eoc_ie = 1'b1; pri_res = 16'h0BEE; pri_eoc = 1'b1;
      tick();
      pri_eoc = 1'b0; eoc_ie = 1'b0;
      check("R9 late primary result reported irq", {31'd0, irq}, 1);
      check("R9 late primary result in data_word", {16'd0, data_word[15:0]}, 32'h0BEE);
      mode_en = 1'b1;
      cnt = 0;
      for (int k = 0; k < 40; k++) begin
         tick();
         if (sec_start || pri_start) cnt++;
      end
      check("R1 re-enable without trigger gives no starts", cnt, 0);
      trig = 1'b1; tick(); trig = 1'b0;
      for (int k = 1; k <= 20; k++) begin
         tick();
         if (sec_start && first_sec < 0) first_sec = k;
         if (pri_start && first_pri < 0) first_pri = k;
      end
      check("R8 restart at phase 0 secondary", first_sec, 1);
      check("R8 restart at phase 0 primary", first_pri, 15);
   endtask

   task automatic t_cont_guard();
      do_reset();
      cont_req = 1'b1; #1;
      check("R3 continuous passes with mode off", {31'd0, cont_eff}, 1);
      mode_en = 1'b1; #1;
      check("R3 continuous forced off with mode on", {31'd0, cont_eff}, 0);
      mode_en = 1'b0; cont_req = 1'b0; #1;
      check("R3 continuous follows request low", {31'd0, cont_eff}, 0);
   endtask

   task automatic t_irq();
      do_reset();
      eoc_ie = 1'b1; pri_eoc = 1'b1; tick(); pri_eoc = 1'b0;
      check("R4 irq after primary eoc", {31'd0, irq}, 1);
      tick();
      check("R4 irq lasts one cycle", {31'd0, irq}, 0);
      eoc_ie = 1'b0; pri_eoc = 1'b1; tick(); pri_eoc = 1'b0;
      check("R4 irq masked when disabled", {31'd0, irq}, 0);
   endtask

   task automatic t_pack();
      do_reset();
      sec_res = 16'hABCD; sec_eoc = 1'b1; tick(); sec_eoc = 1'b0;
      check("R6 secondary eoc alone leaves word", data_word, 32'h0);
      tick();
      pri_res = 16'h1234; pri_eoc = 1'b1; tick(); pri_eoc = 1'b0;
      check("R6 packed word", data_word, 32'hABCD1234);
      sec_res = 16'h5555; pri_res = 16'h6666; sec_eoc = 1'b1; pri_eoc = 1'b1;
      tick(); sec_eoc = 1'b0; pri_eoc = 1'b0;
      check("R6 same-edge packed word", data_word, 32'h55556666);
   endtask

   task automatic t_dma();
      do_reset();
      dma_en = 1'b1; pri_eoc = 1'b1; tick(); pri_eoc = 1'b0;
      check("R5 request raised", {31'd0, dma_req}, 1);
      tick(); tick(); tick();
      check("R5 request held until ack", {31'd0, dma_req}, 1);
      dma_ack = 1'b1; tick(); dma_ack = 1'b0;
      check("R5 request cleared by ack", {31'd0, dma_req}, 0);
      dma_en = 1'b0; pri_eoc = 1'b1; tick(); pri_eoc = 1'b0;
      check("R5 no request when disabled", {31'd0, dma_req}, 0);
      dma_en = 1'b1; pri_eoc = 1'b1; tick();
      dma_ack = 1'b1; tick(); dma_ack = 1'b0; pri_eoc = 1'b0;
      check("R10 ack with new eoc keeps request", {31'd0, dma_req}, 1);
      check("R10 ack with new eoc gives no overrun", {31'd0, ovr_flag}, 0);
      pri_eoc = 1'b1; tick(); pri_eoc = 1'b0;
      check("R10 overrun flagged", {31'd0, ovr_flag}, 1);
      dma_ack = 1'b1; tick(); dma_ack = 1'b0;
      check("R10 overrun sticky after ack", {31'd0, ovr_flag}, 1);
      check("R5 request cleared after overrun ack", {31'd0, dma_req}, 0);
   endtask

   task automatic t_injected();
      do_reset();
      inj_trig = 1'b1; tick(); inj_trig = 1'b0;
      check("R7 injected start passes with mode off", {31'd0, inj_start}, 1);
      check("R7 no error with mode off", {31'd0, inj_err}, 0);
      mode_en = 1'b1;
      inj_trig = 1'b1; tick(); inj_trig = 1'b0;
      check("R7 injected start blocked with mode on", {31'd0, inj_start}, 0);
      check("R7 error flagged with mode on", {31'd0, inj_err}, 1);
      tick();
      check("R7 error sticky", {31'd0, inj_err}, 1);
   endtask

   initial begin
      t_reset_state();
      t_schedule();
      t_ce_divided();
      t_disable();
      t_cont_guard();
      t_irq();
      t_pack();
      t_dma();
      t_injected();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule